// File: doc/BRIEF.md
# I2C Eight-Bit Output Port Expander

This block is an I2C target that owns one 8-bit output port and has no internal register pointer. SCL and SDA are oversampled from a faster system clock. The block detects START, repeated START and STOP on the synchronized lines, receives a 7-bit address and the read/write bit, and acknowledges only its own address.

The upper three address bits are fixed at 1, 0, 1. The lower four bits come from a strap input, so sixteen of these targets can share one bus. A write sends any number of data bytes. Each byte is acknowledged and replaces the whole port at once.

A read returns the levels seen on the port pins through a separate input, not the latched output value. An external pin that is forced against the latch therefore reads back as forced. In a read of several bytes, the pins are sampled again on every master acknowledge, so each byte carries fresh data.

Top module: `i2c_outport`

## Requirements
- R1: After reset the port latch holds all ones and the block does not pull SDA low.
- R2: An address whose upper bits are 101 and whose lower four bits equal the strap is acknowledged: SDA is held low through the high phase of the ninth clock, and the block changes its SDA drive only while SCL is low.
- R3: An address that does not match is not acknowledged, and data bytes that follow it are neither acknowledged nor applied to the port.
- R4: In a write (R/W bit 0), each data byte received MSB first is acknowledged and drives all eight outputs, with the port value changing only at the start of that acknowledge.
- R5: Consecutive data bytes in one write transfer each overwrite the whole port, in order, until STOP.
- R6: In a read (R/W bit 1), the pin levels are sampled at the address acknowledge and sent MSB first, so a pin forced against the latch reads back at its forced level while the latch keeps its value.
- R7: In a multi-byte read, every master acknowledge (SDA low on the ninth clock) resamples the pins, and the next byte carries the new levels. The block releases SDA during each master acknowledge bit.
- R8: After a master NACK (SDA high on the ninth clock), the block stops driving SDA until the next START, so further clocks read all ones.
- R9: A STOP at any bit position ends the transfer. A partly received byte is discarded, and clocks that arrive after STOP without a new START are ignored.
- R10: A repeated START in the middle of a transfer restarts address reception, so a write can be followed by a read without an intervening STOP.
- R11: Changing the strap moves the block to the new address, and the old address is no longer acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_strap | input | 4 | Low four address bits |
| port_pin | input | 8 | Levels observed on the port pins |
| port_out | output | 8 | Port output latch |

## Verification
The bench uses the default parameters: a two-stage synchronizer, fixed address bits 101, a four-bit strap and an all-ones power-up value. The bench master runs SCL at 40 system clocks per bit. That leaves room for the synchronizer delay before the block must hold its acknowledge, and it lets the bench change the forced pin pattern between bytes of a single read. Straps 0xA and 0x3 exercise both address matches and mismatches. An XOR mask on the pin input separates the readback from the latch.

// File: rtl/i2c_outport_pkg.sv
package i2c_outport_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_ADDR,   // shifting address and R/W
        ST_AACK,   // driving address acknowledge
        ST_WDATA,  // shifting a write byte
        ST_WACK,   // driving write acknowledge
        ST_RDATA,  // shifting a read byte out
        ST_RACK,   // listening for master acknowledge
        ST_HOLD    // master declined, silent until START
    } tgt_st_e;

    typedef struct packed {
        tgt_st_e            st;
        logic [3:0]         cnt;
        logic [BYTE_W-1:0]  sh;
        logic               rw;
        logic               macked;
        logic               oe;
        logic [BYTE_W-1:0]  port;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_outport_sync.sv
module i2c_outport_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], din[g]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= chain_d;
            end

            assign dout[g] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/i2c_outport_busmon.sv
module i2c_outport_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_hit,
    output logic stop_hit
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    // SDA edges count as conditions only while SCL stays high on both samples
    assign scl_rise  =  scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s &  prev_q.scl;
    assign start_hit =  scl_s &  prev_q.scl &  prev_q.sda & ~sda_s;
    assign stop_hit  =  scl_s &  prev_q.scl & ~prev_q.sda &  sda_s;

endmodule

// File: rtl/i2c_outport_ctrl.sv
module i2c_outport_ctrl
    import i2c_outport_pkg::*;
#(
    parameter int          FIX_W     = 3,
    parameter logic [FIX_W-1:0] FIX_BITS = 3'b101,
    parameter int          STRAP_W   = 4,
    parameter logic [BYTE_W-1:0] RESET_VAL = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_hit,
    input  logic               stop_hit,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  pins,
    output logic               oe,
    output logic [BYTE_W-1:0]  port,
    output tgt_st_e            st
);

    localparam int ADDR_W   = FIX_W + STRAP_W;
    localparam int LAST_BIT = BYTE_W - 1;

    tgt_regs_t r_d, r_q;
    logic [ADDR_W-1:0] own_addr;

    assign own_addr = {FIX_BITS, strap};

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_ADDR, ST_WDATA: begin
                if (scl_rise) begin
                    r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                    r_d.cnt = r_q.cnt + 4'd1;
                end else if (scl_fall && r_q.cnt == 4'(BYTE_W)) begin
                    if (r_q.st == ST_ADDR) begin
                        if (r_q.sh[BYTE_W-1 -: ADDR_W] == own_addr) begin
                            r_d.st = ST_AACK;
                            r_d.oe = 1'b1;
                            r_d.rw = r_q.sh[0];
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end else begin
                        r_d.st   = ST_WACK;
                        r_d.oe   = 1'b1;
                        r_d.port = r_q.sh;
                    end
                end
            end
            ST_AACK: begin
                if (scl_rise && r_q.rw) begin
                    r_d.sh = pins;
                end else if (scl_fall) begin
                    r_d.cnt = '0;
                    if (r_q.rw) begin
                        r_d.st = ST_RDATA;
                        r_d.oe = ~r_q.sh[LAST_BIT];
                    end else begin
                        r_d.st = ST_WDATA;
                        r_d.oe = 1'b0;
                    end
                end
            end
            ST_WACK: begin
                if (scl_fall) begin
                    r_d.st  = ST_WDATA;
                    r_d.oe  = 1'b0;
                    r_d.cnt = '0;
                end
            end
            ST_RDATA: begin
                if (scl_fall) begin
                    if (r_q.cnt == 4'(LAST_BIT)) begin
                        r_d.st = ST_RACK;
                        r_d.oe = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt + 4'd1;
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], 1'b0};
                        r_d.oe  = ~r_q.sh[LAST_BIT-1];
                    end
                end
            end
            ST_RACK: begin
                if (scl_rise) begin
                    r_d.macked = ~sda_s;
                    if (!sda_s) r_d.sh = pins;
                end else if (scl_fall) begin
                    if (r_q.macked) begin
                        r_d.st  = ST_RDATA;
                        r_d.cnt = '0;
                        r_d.oe  = ~r_q.sh[LAST_BIT];
                    end else begin
                        r_d.st = ST_HOLD;
                        r_d.oe = 1'b0;
                    end
                end
            end
            default: ;
        endcase

        // bus conditions win over any bit-level progress
        if (start_hit) begin
            r_d.st  = ST_ADDR;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else if (stop_hit) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, sh: '0, rw: 1'b0,
                     macked: 1'b0, oe: 1'b0, port: RESET_VAL};
        end else begin
            r_q <= r_d;
        end
    end

    assign oe   = r_q.oe;
    assign port = r_q.port;
    assign st   = r_q.st;

endmodule

// File: rtl/i2c_outport.sv
module i2c_outport
    import i2c_outport_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter int                 FIX_W       = 3,
    parameter logic [FIX_W-1:0]   FIX_BITS    = 3'b101,
    parameter int                 STRAP_W     = 4,
    parameter logic [BYTE_W-1:0]  RESET_VAL   = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic [BYTE_W-1:0]  port_pin,
    output logic [BYTE_W-1:0]  port_out
);

    localparam int SCL_IDX = 1;
    localparam int SDA_IDX = 0;

    logic [1:0] lines_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_hit, stop_hit;
    tgt_st_e    st;

    i2c_outport_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_in, sda_in}),
        .dout  (lines_s)
    );

    assign scl_s = lines_s[SCL_IDX];
    assign sda_s = lines_s[SDA_IDX];

    i2c_outport_busmon u_busmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_hit (start_hit),
        .stop_hit  (stop_hit)
    );

    i2c_outport_ctrl #(
        .FIX_W     (FIX_W),
        .FIX_BITS  (FIX_BITS),
        .STRAP_W   (STRAP_W),
        .RESET_VAL (RESET_VAL)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_hit (start_hit),
        .stop_hit  (stop_hit),
        .strap     (addr_strap),
        .pins      (port_pin),
        .oe        (sda_oe),
        .port      (port_out),
        .st        (st)
    );

endmodule

// File: rtl/i2c_outport_chk.sv
module i2c_outport_chk
    import i2c_outport_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input logic [BYTE_W-1:0] port_out,
    input tgt_st_e           st
);

    // R1: leaving reset with the power-up latch value and SDA released
    p_reset_val_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (port_out == '1 && !sda_oe));

    // R2: SDA drive moves only during the low phase of SCL
    p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R3: no drive while an address is still being received
    p_addr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR) |-> !sda_oe);

    // R4: the latch moves only as a write acknowledge begins
    p_port_on_wack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_out != $past(port_out)) |-> (st == ST_WACK));

    // R7: released while the master gives its acknowledge
    p_rack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RACK) |-> !sda_oe);

    // R8: silent after a master NACK
    p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> !sda_oe);

endmodule

bind i2c_outport i2c_outport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .port_out (port_out),
    .st       (st)
);

// File: tb/i2c_outport_bench.sv
`timescale 1ns/1ps
module i2c_outport_bench;

    localparam int Q = 10;   // quarter SCL period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [3:0] strap = 4'hA;
    logic [7:0] force_mask = 8'h00;
    logic [7:0] port_out;
    logic [7:0] port_pin;
    logic       sda_line;
    logic       oe_seen = 1'b0;
    int         n_run = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign sda_line = sda_m & ~sda_oe;
    assign port_pin = port_out ^ force_mask;

    always @(posedge clk) if (sda_oe) oe_seen <= 1'b1;

    i2c_outport u_i2c_outport (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .addr_strap (strap),
        .port_pin   (port_pin),
        .port_out   (port_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(posedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b1; wait_q(2);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wait_q(1);
        scl_m = 1'b1; wait_q(2);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        @(negedge clk) b = sda_line;
        wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, input logic [7:0] next_mask,
                             output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        force_mask = next_mask;
        put_bit(~give_ack);
    endtask

    function automatic logic [7:0] addr_byte(input logic [3:0] s, input logic rd);
        return {3'b101, s, rd};
    endfunction

    task automatic t_reset;
        @(negedge clk);
        chk("R1 port after reset", port_out, 8'hFF);
        chk("R1 sda released after reset", sda_oe, 1'b0);
    endtask

    task automatic t_write_single;
        logic a;
        bus_start;
        send_byte(addr_byte(4'hA, 1'b0), a);
        chk("R2 address ack", a, 1'b1);
        send_byte(8'h3C, a);
        chk("R4 data ack", a, 1'b1);
        chk("R4 port value", port_out, 8'h3C);
        bus_stop;
    endtask

    task automatic t_write_multi;
        logic a;
        logic [7:0] seq [3] = '{8'h81, 8'h7E, 8'h00};
        bus_start;
        send_byte(addr_byte(4'hA, 1'b0), a);
        for (int i = 0; i < 3; i++) begin
            send_byte(seq[i], a);
            chk("R5 byte ack", a, 1'b1);
            chk("R5 port overwrite", port_out, seq[i]);
        end
        bus_stop;
    endtask

    task automatic t_read_forced;
        logic a;
        logic [7:0] v;
        force_mask = 8'h0F;
        bus_start;
        send_byte(addr_byte(4'hA, 1'b1), a);
        chk("R6 read address ack", a, 1'b1);
        recv_byte(1'b0, 8'h0F, v);
        bus_stop;
        chk("R6 pin readback", v, 8'h0F);
        chk("R6 latch kept", port_out, 8'h00);
        force_mask = 8'h00;
    endtask

    task automatic t_read_multi;
        logic a;
        logic [7:0] v;
        force_mask = 8'hA5;
        bus_start;
        send_byte(addr_byte(4'hA, 1'b1), a);
        recv_byte(1'b1, 8'h5A, v);
        chk("R7 first byte", v, 8'hA5);
        recv_byte(1'b1, 8'hFF, v);
        chk("R7 resampled second byte", v, 8'h5A);
        recv_byte(1'b0, 8'h00, v);
        chk("R7 resampled third byte", v, 8'hFF);
        bus_stop;
    endtask

    task automatic t_nack;
        logic a;
        logic b;
        logic [7:0] v;
        force_mask = 8'h00;
        bus_start;
        send_byte(addr_byte(4'hA, 1'b1), a);
        recv_byte(1'b0, 8'h00, v);
        wait_q(1);
        oe_seen = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        chk("R8 bits after nack", v, 8'hFF);
        chk("R8 no drive after nack", oe_seen, 1'b0);
        bus_stop;
    endtask

    task automatic t_wrong_addr;
        logic a;
        bus_start;
        send_byte(addr_byte(4'hB, 1'b0), a);
        chk("R3 foreign address not acked", a, 1'b0);
        send_byte(8'h12, a);
        chk("R3 data not acked", a, 1'b0);
        chk("R3 port untouched", port_out, 8'h00);
        bus_stop;
    endtask

    task automatic t_stop_abort;
        logic a;
        bus_start;
        send_byte(addr_byte(4'hA, 1'b0), a);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop;
        chk("R9 partial byte discarded", port_out, 8'h00);
        send_byte(8'hF0, a);
        chk("R9 clocks after stop not acked", a, 1'b0);
        chk("R9 port untouched after stop", port_out, 8'h00);
        bus_stop;
    endtask

    task automatic t_rep_start;
        logic a;
        logic [7:0] v;
        bus_start;
        send_byte(addr_byte(4'hA, 1'b0), a);
        send_byte(8'h55, a);
        bus_start;
        send_byte(addr_byte(4'hA, 1'b1), a);
        chk("R10 address after repeated start", a, 1'b1);
        recv_byte(1'b0, 8'h00, v);
        chk("R10 read after repeated start", v, 8'h55);
        bus_stop;
    endtask

    task automatic t_strap;
        logic a;
        strap = 4'h3;
        wait_q(1);
        bus_start;
        send_byte(addr_byte(4'hA, 1'b0), a);
        chk("R11 old address ignored", a, 1'b0);
        bus_stop;
        bus_start;
        send_byte(addr_byte(4'h3, 1'b0), a);
        chk("R11 new address acked", a, 1'b1);
        send_byte(8'h99, a);
        chk("R11 write at new address", port_out, 8'h99);
        bus_stop;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset;
        wait_q(2);
        t_write_single;
        t_write_multi;
        t_read_forced;
        t_read_multi;
        t_nack;
        t_wrong_addr;
        t_stop_abort;
        t_rep_start;
        t_write_multi;
        t_strap;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule